// File: doc/BRIEF.md
# Eight-bit general-purpose I/O port controller

This block is the register-side logic of an 8-bit general-purpose I/O port. Software uses a small register bus to set a direction mask and an output mask. From these two masks and a single global pull-up kill input, the block derives three controls for each pin: drive enable, drive value and pull-up enable. The pad ring then acts on those controls.

The pin levels come back through a two-stage synchronizer. The first stage is a latch that is transparent while the clock is low. The second stage is a flop that captures on the rising edge. The synchronized levels can be read at any time, whatever direction each pin has, so a bit that is driving can also be read back.

Writing ones to the pin-level address flips the matching output bits. This lets software invert individual bits without a read-modify-write.

Top module: `gpio_port`

## Requirements
- R1: While and after reset, the direction mask and the output mask are all zero, so every pin has drive enable 0 and pull-up enable 0. A read at address 1 or address 2 returns 0x00.
- R2: A write at address 1 loads the direction mask on the next rising edge. From then on, drive_en equals the mask (bit set = output), and a read at address 1 returns it.
- R3: A write at address 2 loads the output mask on the next rising edge. From then on, drive_val equals the mask, so a pin with drive enabled is driven high for 1 and low for 0. A read at address 2 returns the mask.
- R4: A write at address 0 inverts each output-mask bit whose write-data bit is 1 and keeps each bit whose write-data bit is 0, whatever the direction mask holds. The direction mask is unchanged.
- R5: The pull-up enable of a bit is 1 only when that bit's direction is 0, its output bit is 1 and pud_i is 0. It is never 1 for a bit with drive enabled.
- R6: While pud_i is 1, every pull-up enable is 0. Clearing pud_i restores the pull-ups given by R5 in the same cycle.
- R7: A read at address 0 returns the synchronized level of all eight pins, including pins whose drive is enabled.
- R8: A pin change made while the clock is low appears in the address-0 read value just after the next rising edge. A change made while the clock is high does not appear at the rising edge that comes before it. It appears after the rising edge that follows the next falling edge.
- R9: Address 3 reads as 0x00, and a write there changes neither mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the synchronizer latch is open while it is low |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 pin levels / toggle, 1 direction, 2 output, 3 unused |
| we | input | 1 | Write strobe, taken on the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address, combinational |
| pud_i | input | 1 | Global pull-up disable, applies to all bits |
| pin_i | input | 8 | Raw pin levels from the pads |
| drive_en | output | 8 | Per-pin output driver enable |
| drive_val | output | 8 | Per-pin driven level |
| pull_en | output | 8 | Per-pin pull-up enable |

## Verification
Register writes take effect at the rising edge that follows the write strobe. Each expected item therefore carries a due cycle one edge after the falling edge that drove it, and the monitor compares it shortly after that edge. Read data and pull-up enables follow their inputs combinationally, so a read or a change of pud_i is due at the same next sample. Pin changes are applied either during the low phase or during the high phase. For a high-phase change the bench queues two items: the old level, due at the sample just after the current edge, and the new level, due one edge later. A path that skips the latch or that adds a stage is caught in this way.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_PIN  = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_OUT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic ov;
        logic pu;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_decode(input logic dir, input logic out, input logic pud);
        pad_ctl_t c;
        c.oe = dir;
        c.ov = out;
        c.pu = !dir && out && !pud;
        return c;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_sel_e     sel,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_DIR: dir_q <= wdata;
                SEL_OUT: out_q <= wdata;
                SEL_PIN: out_q <= out_q ^ wdata;
                default: ;
            endcase
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (dir_q == '0) && (out_q == '0));

    a_r2_dir_load: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_DIR) |=> dir_q == $past(wdata));

    a_r4_toggle: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_PIN) |=> (out_q == ($past(out_q) ^ $past(wdata))) && $stable(dir_q));

    a_r9_unused_write: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_NONE) |=> $stable(dir_q) && $stable(out_q));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_q
);

    logic [W-1:0] lat_q;

    always_latch begin
        if (!clk) lat_q = pin_i;
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= lat_q;
    end

endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] out_q,
    input  logic         pud_i,
    output logic [W-1:0] drive_en,
    output logic [W-1:0] drive_val,
    output logic [W-1:0] pull_en
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        pad_ctl_t ctl;
        assign ctl          = pad_decode(dir_q[i], out_q[i], pud_i);
        assign drive_en[i]  = ctl.oe;
        assign drive_val[i] = ctl.ov;
        assign pull_en[i]   = ctl.pu;
    end

    a_r5_no_pull_on_output: assert property (@(posedge clk) disable iff (rst)
        (pull_en & drive_en) == '0);

    a_r6_global_disable: assert property (@(posedge clk) disable iff (rst)
        pud_i |-> pull_en == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   addr,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         pud_i,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] drive_en,
    output logic [W-1:0] drive_val,
    output logic [W-1:0] pull_en
);

    reg_sel_e     sel;
    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] level_q;

    assign sel = reg_sel_e'(addr);

    gpio_port_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .wdata(wdata),
        .dir_q(dir_q), .out_q(out_q)
    );

    gpio_port_sync #(.W(W)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_i), .level_q(level_q)
    );

    gpio_port_pads #(.W(W)) u_pads (
        .clk(clk), .rst(rst), .dir_q(dir_q), .out_q(out_q), .pud_i(pud_i),
        .drive_en(drive_en), .drive_val(drive_val), .pull_en(pull_en)
    );

    always_comb begin
        case (sel)
            SEL_PIN: rdata = level_q;
            SEL_DIR: rdata = dir_q;
            SEL_OUT: rdata = out_q;
            default: rdata = '0;
        endcase
    end

    a_r9_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> rdata == '0);

endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/100ps
module tb_gpio_port;

    typedef struct {
        int        due;
        int        kind;
        logic [7:0] exp;
        string     tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr;
    logic       we;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       pud_i;
    logic [7:0] pin_i;
    logic [7:0] drive_en, drive_val, pull_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    item_t q[$];
    logic [7:0] dir_m, out_m;

    gpio_port dut (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
        .pud_i(pud_i), .pin_i(pin_i), .drive_en(drive_en), .drive_val(drive_val),
        .pull_en(pull_en)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] actual(int kind);
        case (kind)
            0: return rdata;
            1: return drive_en;
            2: return drive_val;
            default: return pull_en;
        endcase
    endfunction

    always @(posedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [7:0] a;
            it = q.pop_front();
            a = actual(it.kind);
            checks++;
            if (it.due != cyc) begin
                failures++;
                $display("FAIL %s kind=%0d missed due cycle %0d (now %0d)", it.tag, it.kind, it.due, cyc);
            end else if (a !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, a, it.exp);
            end
        end
    end

    task automatic push(int due, int kind, logic [7:0] exp, string tag);
        item_t it;
        it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic push_pads(int due, string tag);
        push(due, 1, dir_m, tag);
        push(due, 2, out_m, tag);
        push(due, 3, ~dir_m & out_m & {8{~pud_i}}, tag);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        case (a)
            2'd0: out_m = out_m ^ d;
            2'd1: dir_m = d;
            2'd2: out_m = d;
            default: ;
        endcase
        push_pads(cyc + 1, tag);
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        addr = a; we = 1'b0;
        push(cyc + 1, 0, exp, tag);
        push_pads(cyc + 1, tag);
    endtask

    task automatic set_pud(logic v, string tag);
        @(negedge clk);
        we = 1'b0; pud_i = v;
        push_pads(cyc + 1, tag);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = 2'd0; we = 1'b0; wdata = 8'h00; pud_i = 1'b0; pin_i = 8'h00;
        dir_m = 8'h00; out_m = 8'h00;
        repeat (4) @(negedge clk);
        push_pads(cyc + 1, "R1 reset");
        @(negedge clk);
        rst = 1'b0;
        rd(2'd1, 8'h00, "R1 dir after reset");
        rd(2'd2, 8'h00, "R1 out after reset");

        wr(2'd1, 8'hF0, "R2 dir write");
        rd(2'd1, 8'hF0, "R2 dir readback");
        wr(2'd2, 8'h3C, "R3 out write");
        rd(2'd2, 8'h3C, "R3 out readback");
        wr(2'd2, 8'hA5, "R3 out write 2");
        wr(2'd1, 8'h0F, "R2 dir write 2");

        wr(2'd0, 8'h81, "R4 toggle");
        rd(2'd2, 8'h24, "R4 toggle result");
        rd(2'd1, 8'h0F, "R4 dir unchanged");
        wr(2'd0, 8'h00, "R4 zero toggle");
        rd(2'd2, 8'h24, "R4 zero leaves out");
        wr(2'd1, 8'h00, "R5 all inputs");
        wr(2'd0, 8'hFF, "R4 toggle all inputs");
        rd(2'd2, 8'hDB, "R4 toggle with dir 0");

        wr(2'd2, 8'hFF, "R5 all pullups");
        wr(2'd1, 8'h55, "R5 outputs no pull");
        set_pud(1'b1, "R6 pud set");
        wr(2'd1, 8'h00, "R6 inputs pud set");
        set_pud(1'b0, "R6 pud clear");

        wr(2'd3, 8'hFF, "R9 unused write");
        rd(2'd3, 8'h00, "R9 unused read");
        rd(2'd1, 8'h00, "R9 dir kept");
        rd(2'd2, 8'hFF, "R9 out kept");

        wr(2'd1, 8'hFF, "R7 all outputs");
        @(negedge clk);
        we = 1'b0; addr = 2'd0; pin_i = 8'h5A;
        @(negedge clk);
        push(cyc + 1, 0, 8'h5A, "R7 read pins as outputs");
        @(negedge clk);
        wr(2'd1, 8'h00, "R7 all inputs");
        @(negedge clk);
        we = 1'b0; addr = 2'd0; pin_i = 8'hC3;
        @(negedge clk);
        push(cyc + 1, 0, 8'hC3, "R7 read pins as inputs");
        settle();

        @(negedge clk);
        #0.5 pin_i = 8'h11;
        push(cyc + 1, 0, 8'h11, "R8 low-phase change");
        settle();

        @(posedge clk);
        #0.5 pin_i = 8'hEE;
        push(cyc, 0, 8'h11, "R8 high-phase not at current edge");
        push(cyc + 1, 0, 8'hEE, "R8 high-phase after next edge");
        settle();

        @(negedge clk);
        #1.5 pin_i = 8'h77;
        push(cyc + 1, 0, 8'h77, "R8 change late in low phase");
        settle();
        settle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule